// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block collects an outgoing Ethernet frame that software pushes in as 32-bit words and hands it to a downstream MAC as a byte stream. The first word of every frame is an in-band header whose low 16 bits give the payload length. The following words carry the destination and source addresses, the type field and the payload. Each word is kept as four bytes in a 2048-byte store.

After every accepted word the block evaluates two conditions. The first is whether the stored byte count has reached a quantised fill threshold. The second is whether the whole frame, including the optional trailing check field, has arrived. When both hold, the frame is sent without further action. A transmit-request strobe starts a send at any time, whatever the fill state. The frame is streamed from the byte after the two header bytes. It can be zero-padded up to the minimum Ethernet frame size.

Two sticky status outputs report a rejected over-long header and a completed send. Each has its own acknowledge strobe. Acknowledging the error also discards everything that has been stored.

Top module: `eth_tx_assembler`

## Requirements
- R1: After reset, `fill_count` is 0, `busy`, `tx_valid`, `st_txerr` and `st_txempty` are 0, and the threshold code is all ones.
- R2: An accepted data write stores its word as four bytes, least significant byte first, and raises `fill_count` by 4. A write arriving with fewer than 4 free bytes is dropped and leaves `fill_count` unchanged.
- R3: When `fill_count` is 0, bits [15:0] of the written word are the payload length. A length above 2032 discards the word, keeps `fill_count` at 0 and sets `st_txerr`.
- R4: A frame is complete when `fill_count` is at least the payload length + 16. The minimum is 4 bytes higher while `crc_en` is 0, and the required count never exceeds 2048.
- R5: The threshold is met when `thresh` is not all ones and `fill_count` is at least 4 × (8 × `thresh` + 1). The all-ones code disables automatic sending.
- R6: An accepted data write that leaves the store both at threshold and complete starts a send. `busy` and `tx_valid` are then high one clock edge after the write.
- R7: A `tx_req` pulse while idle starts a send of whatever is stored, complete or not.
- R8: The stream carries payload length + 14 bytes, taken in order from store byte 2 onward. `tx_last` marks the final byte. Bytes at positions never written in the current frame are sent as zero.
- R9: With `pad_en` high, a frame shorter than 60 bytes is extended to 60 bytes with zeros. No frame is ever longer than 2046 bytes.
- R10: On the edge where the final byte is accepted, the store is emptied, `busy` falls and `st_txempty` is set.
- R11: `ack_txerr` clears `st_txerr` and empties the store. `ack_txempty` clears `st_txempty`. A set and a clear arriving on the same edge leave the bit set.
- R12: While `busy` is high, data writes and `tx_req` are ignored, `fill_count` holds its value, and a stalled byte (`tx_valid` high with `tx_ready` low) keeps its data and `tx_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_wr | input | 1 | Data word write strobe |
| data_word | input | 32 | Word to store; when the store is empty, bits [15:0] hold the payload length |
| tx_req | input | 1 | Manual send request strobe |
| pad_en | input | 1 | Pad short frames to 60 bytes |
| crc_en | input | 1 | Check field is added downstream, so it is not expected in the store |
| thresh | input | 6 | Fill threshold code; all ones disables automatic sending |
| ack_txerr | input | 1 | Clears the error status and empties the store |
| ack_txempty | input | 1 | Clears the send-done status |
| st_txerr | output | 1 | Over-long header was rejected |
| st_txempty | output | 1 | A frame has been sent |
| busy | output | 1 | A frame is being streamed out |
| fill_count | output | 12 | Bytes currently stored |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
A data write presented before an edge takes effect on that edge: `fill_count`, `st_txerr` and, for an automatic send, `busy` change there. A `tx_req` pulse starts the send on the same edge. Acceptance of the last byte clears `busy`, empties the store and sets `st_txempty` on that edge. Inputs are driven on falling edges, and every result is read on the next falling edge, half a cycle after the edge that produced it. The stream is consumed under a stall pattern, and each byte is recorded only in a cycle where both valid and ready are high. Each threshold and completeness boundary is probed with the word just below it (no send) and the word that reaches it (send).

// File: rtl/txasm_pkg.sv
// Shared constants and types for the transmit frame assembler.
package txasm_pkg;
    localparam int LEN_W     = 16;   // width of the in-band payload length
    localparam int LEN_HDR   = 2;    // bytes of in-band length at the store head
    localparam int ETH_HDR   = 14;   // addresses plus type field
    localparam int CRC_BYTES = 4;    // check field expected in the store when not added downstream
    localparam int MIN_FRAME = 60;   // minimum frame before the check field

    // Everything the streaming stage needs, latched when a send starts.
    typedef struct packed {
        logic [LEN_W-1:0] sent_len;  // bytes to emit
        logic [LEN_W-1:0] data_lim;  // positions at or above this are pad bytes
        logic [LEN_W-1:0] stored;    // store bytes that were written for this frame
    } frame_plan_t;
endpackage

// File: rtl/txasm_fifo.sv
// Word-wide byte store with fill counter and captured header length.
// Assumes the caller only pushes while at least four bytes are free and
// never pushes during a send; flush wins over push on the same edge.
module txasm_fifo #(
    parameter int FIFO_BYTES = 2048,
    localparam int BW    = $clog2(FIFO_BYTES),
    localparam int CW    = BW + 1,
    localparam int WORDS = FIFO_BYTES / 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [31:0]   wdata,
    input  logic          flush,
    output logic [CW-1:0] count,
    output logic [15:0]   hdr_len,
    input  logic [BW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);
    logic [31:0]   mem [WORDS];
    logic [CW-1:0] count_q;
    logic [15:0]   len_q;

    // Store the pushed word at the current fill position.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[count_q[BW-1:2]] <= wdata;
        end
    end

    // Track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count_q <= '0;
        end else if (push) begin
            count_q <= count_q + CW'(4);
        end
    end

    // Capture the payload length from the first word of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            len_q <= '0;
        end else if (push && count_q == '0) begin
            len_q <= wdata[15:0];
        end
    end

    // Pick one byte of the addressed word, least significant first.
    always_comb begin
        logic [31:0] word;
        word    = mem[rd_idx[BW-1:2]];
        rd_byte = word[8*rd_idx[1:0] +: 8];
    end

    assign count   = count_q;
    assign hdr_len = len_q;
endmodule

// File: rtl/txasm_policy.sv
// Combinational send policy: threshold and completeness decisions plus the
// length plan of the frame. Assumes the length was checked on entry.
module txasm_policy
    import txasm_pkg::*;
#(
    parameter int FIFO_BYTES = 2048,
    parameter int THR_W      = 6,
    localparam int CW        = $clog2(FIFO_BYTES) + 1
) (
    input  logic [CW-1:0]    fill,
    input  logic [LEN_W-1:0] len,
    input  logic             crc_en,
    input  logic             pad_en,
    input  logic [THR_W-1:0] thresh,
    output logic             thr_met,
    output logic             complete,
    output frame_plan_t      plan
);
    localparam logic [THR_W-1:0] THR_OFF = '1;
    localparam logic [16:0] CAP_NEED = 17'(FIFO_BYTES);
    localparam logic [16:0] CAP_SEND = 17'(FIFO_BYTES - LEN_HDR);

    logic [16:0] need_raw, need, thr_bytes, base, padded, sent;

    // Bytes required before the frame counts as complete.
    always_comb begin
        need_raw = {1'b0, len} + 17'(ETH_HDR + LEN_HDR)
                 + (crc_en ? 17'd0 : 17'(CRC_BYTES));
        need     = (need_raw > CAP_NEED) ? CAP_NEED : need_raw;
        complete = 17'(fill) >= need;
    end

    // Quantised fill threshold, off at the all-ones code.
    always_comb begin
        thr_bytes = (17'(thresh) * 17'd8 + 17'd1) * 17'd4;
        thr_met   = (thresh != THR_OFF) && (17'(fill) >= thr_bytes);
    end

    // Emitted length with optional padding and the store cap.
    always_comb begin
        base   = {1'b0, len} + 17'(ETH_HDR);
        padded = (pad_en && base < 17'(MIN_FRAME)) ? 17'(MIN_FRAME) : base;
        sent   = (padded > CAP_SEND) ? CAP_SEND : padded;
        plan.sent_len = sent[LEN_W-1:0];
        plan.data_lim = base[LEN_W-1:0];
        plan.stored   = LEN_W'(fill);
    end
endmodule

// File: rtl/txasm_stream.sv
// Byte streamer: walks the latched frame plan and drives a valid/ready
// byte stream. Assumes the store is not written while busy.
module txasm_stream
    import txasm_pkg::*;
#(
    parameter int FIFO_BYTES = 2048,
    localparam int BW        = $clog2(FIFO_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  frame_plan_t   plan_in,
    output logic [BW-1:0] rd_idx,
    input  logic [7:0]    rd_byte,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          busy,
    output logic          done
);
    logic             busy_q;
    logic [LEN_W-1:0] pos_q;
    frame_plan_t      plan_q;
    logic [LEN_W-1:0] idx;
    logic             in_data;

    // Start, advance and finish the byte walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
            plan_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                pos_q  <= '0;
                plan_q <= plan_in;
            end
        end else if (tx_ready) begin
            if (tx_last) begin
                busy_q <= 1'b0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // Map the stream position to a store byte or a zero byte.
    always_comb begin
        idx     = pos_q + LEN_W'(LEN_HDR);
        rd_idx  = idx[BW-1:0];
        in_data = (pos_q < plan_q.data_lim) && (idx < plan_q.stored);
        tx_data = (busy_q && in_data) ? rd_byte : 8'h00;
    end

    assign tx_valid = busy_q;
    assign tx_last  = busy_q && (pos_q == plan_q.sent_len - 1'b1);
    assign busy     = busy_q;
    assign done     = busy_q && tx_ready && tx_last;
endmodule

// File: rtl/eth_tx_assembler.sv
// Transmit frame assembler top: accepts header and data words, applies the
// length check, the threshold and completeness policy, and the manual
// request, then hands the frame to the streamer. Status bits are sticky
// until acknowledged; a set on the same edge as its clear wins.
module eth_tx_assembler
    import txasm_pkg::*;
#(
    parameter int FIFO_BYTES = 2048,
    parameter int THR_W      = 6,
    localparam int BW        = $clog2(FIFO_BYTES),
    localparam int CW        = BW + 1,
    localparam int MAX_PAYLOAD = FIFO_BYTES - ETH_HDR - LEN_HDR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [31:0]      data_word,
    input  logic             tx_req,
    input  logic             pad_en,
    input  logic             crc_en,
    input  logic [THR_W-1:0] thresh,
    input  logic             ack_txerr,
    input  logic             ack_txempty,
    output logic             st_txerr,
    output logic             st_txempty,
    output logic             busy,
    output logic [CW-1:0]    fill_count,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic             tx_last
);
    logic [CW-1:0]    count, cnt_after;
    logic [LEN_W-1:0] hdr_len, len_after;
    logic             accept, first, too_long, push, flush;
    logic             thr_met, complete, auto_go, start, done;
    logic [BW-1:0]    rd_idx;
    logic [7:0]       rd_byte;
    frame_plan_t      plan;
    logic             txerr_q, txempty_q;

    // Decide what an incoming word does and the state it would leave.
    always_comb begin
        accept    = data_wr && !busy;
        first     = (count == '0);
        too_long  = accept && first && (data_word[15:0] > 16'(MAX_PAYLOAD));
        push      = accept && !too_long && (32'(count) + 32'd4 <= 32'(FIFO_BYTES));
        cnt_after = push ? count + CW'(4) : count;
        len_after = (push && first) ? data_word[15:0] : hdr_len;
        auto_go   = accept && !too_long && thr_met && complete;
        start     = !busy && (auto_go || tx_req);
        flush     = done || ack_txerr;
    end

    txasm_fifo #(.FIFO_BYTES(FIFO_BYTES)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wdata   (data_word),
        .flush   (flush),
        .count   (count),
        .hdr_len (hdr_len),
        .rd_idx  (rd_idx),
        .rd_byte (rd_byte)
    );

    txasm_policy #(.FIFO_BYTES(FIFO_BYTES), .THR_W(THR_W)) policy_i (
        .fill     (cnt_after),
        .len      (len_after),
        .crc_en   (crc_en),
        .pad_en   (pad_en),
        .thresh   (thresh),
        .thr_met  (thr_met),
        .complete (complete),
        .plan     (plan)
    );

    txasm_stream #(.FIFO_BYTES(FIFO_BYTES)) stream_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .plan_in  (plan),
        .rd_idx   (rd_idx),
        .rd_byte  (rd_byte),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .busy     (busy),
        .done     (done)
    );

    // Sticky error status: set by a rejected header, cleared by its ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txerr_q <= 1'b0;
        end else if (too_long) begin
            txerr_q <= 1'b1;
        end else if (ack_txerr) begin
            txerr_q <= 1'b0;
        end
    end

    // Sticky send-done status: set at the end of a send, cleared by its ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txempty_q <= 1'b0;
        end else if (done) begin
            txempty_q <= 1'b1;
        end else if (ack_txempty) begin
            txempty_q <= 1'b0;
        end
    end

    assign st_txerr   = txerr_q;
    assign st_txempty = txempty_q;
    assign fill_count = count;
endmodule

// File: rtl/eth_tx_assembler_chk.sv
// Protocol checker for the transmit frame assembler, bound to the top.
module eth_tx_assembler_chk #(
    parameter int FIFO_BYTES = 2048,
    localparam int CW        = $clog2(FIFO_BYTES) + 1,
    localparam int MAXP      = FIFO_BYTES - 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          data_wr,
    input logic [31:0]   data_word,
    input logic          ack_txerr,
    input logic          busy,
    input logic          st_txerr,
    input logic          st_txempty,
    input logic [CW-1:0] fill_count,
    input logic [7:0]    tx_data,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          tx_last
);
    // R2: the fill level stays word aligned and within the store.
    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(fill_count) <= FIFO_BYTES) && (fill_count[1:0] == 2'b00));

    // R3: an over-long header leaves the store empty and flags an error.
    p_too_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !busy && fill_count == '0 && 32'(data_word[15:0]) > MAXP)
        |=> (st_txerr && fill_count == '0));

    // R10: accepting the final byte ends the send and empties the store.
    p_send_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last)
        |=> (st_txempty && !busy && fill_count == '0));

    // R11: the error acknowledge clears the flag and flushes the store.
    p_err_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_txerr && !data_wr) |=> (!st_txerr && fill_count == '0));

    // R12: a stalled byte holds its value and its last marker.
    p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready)
        |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R12: the store does not change while a frame is streaming.
    p_busy_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(tx_ready && tx_last) && !ack_txerr) |=> $stable(fill_count));
endmodule

bind eth_tx_assembler eth_tx_assembler_chk #(.FIFO_BYTES(FIFO_BYTES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_wr    (data_wr),
    .data_word  (data_word),
    .ack_txerr  (ack_txerr),
    .busy       (busy),
    .st_txerr   (st_txerr),
    .st_txempty (st_txempty),
    .fill_count (fill_count),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_last    (tx_last)
);

// File: tb/eth_tx_assembler_tb_top.sv
// Directed bench for the transmit frame assembler.
module eth_tx_assembler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_wr = 1'b0;
    logic [31:0] data_word = '0;
    logic        tx_req = 1'b0;
    logic        pad_en = 1'b0;
    logic        crc_en = 1'b1;
    logic [5:0]  thresh = 6'h3F;
    logic        ack_txerr = 1'b0;
    logic        ack_txempty = 1'b0;
    logic        st_txerr, st_txempty, busy;
    logic [11:0] fill_count;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    // Bench model of the store, filled from the words it writes.
    logic [7:0]  model [2048];
    int          mcount = 0;
    int          mlen = 0;

    always #10 clk = ~clk;  // 50 MHz

    eth_tx_assembler dut_i (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_word(data_word),
        .tx_req(tx_req), .pad_en(pad_en), .crc_en(crc_en), .thresh(thresh),
        .ack_txerr(ack_txerr), .ack_txempty(ack_txempty),
        .st_txerr(st_txerr), .st_txempty(st_txempty), .busy(busy),
        .fill_count(fill_count), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_last(tx_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'h9E37_79B9 * k + 32'h0102_0304;
    endfunction

    function automatic logic [7:0] exp_byte(input int p);
        int idx = p + 2;
        if (p < mlen + 14 && idx < mcount) return model[idx];
        return 8'h00;
    endfunction

    // One data write; results are read at the following falling edge.
    task automatic wr_word(input logic [31:0] w);
        @(negedge clk);
        data_wr = 1'b1;
        data_word = w;
        if (mcount == 0 && w[15:0] > 16'd2032) begin
        end else if (mcount + 4 <= 2048) begin
            for (int b = 0; b < 4; b++) model[mcount + b] = w[8*b +: 8];
            if (mcount == 0) mlen = int'(w[15:0]);
            mcount += 4;
        end
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    // Header plus n-1 pattern words; no check after the last.
    task automatic fill_frame(input int len, input int nwords);
        wr_word({16'hC0DE, 16'(len)});
        for (int k = 1; k < nwords; k++) wr_word(pat(k));
    endtask

    task automatic pulse_req();
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic ack_err();
        @(negedge clk);
        ack_txerr = 1'b1;
        @(negedge clk);
        ack_txerr = 1'b0;
        mcount = 0;
        mlen = 0;
    endtask

    // Consume one frame under a stall pattern and compare it to the model.
    task automatic recv_frame(input int exp_len, input string req, input bit poke);
        int n = 0;
        int bad = 0;
        int bad_act = 0;
        int bad_exp = 0;
        bit seen_last = 1'b0;
        for (int cyc = 0; cyc < 6000 && !seen_last; cyc++) begin
            @(negedge clk);
            tx_ready = (cyc % 3) != 1;
            if (poke && cyc == 4) begin
                data_wr = 1'b1;
                data_word = 32'h5A5A_5A5A;
                tx_req = 1'b1;
            end else begin
                data_wr = 1'b0;
                tx_req = 1'b0;
            end
            if (tx_valid && tx_ready) begin
                if (tx_data !== exp_byte(n) || (tx_last && n != exp_len - 1)) begin
                    if (bad == 0) begin
                        bad_act = int'(tx_data);
                        bad_exp = int'(exp_byte(n));
                    end
                    bad++;
                end
                if (tx_last) seen_last = 1'b1;
                n++;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
        data_wr = 1'b0;
        tx_req = 1'b0;
        chk(n == exp_len, {req, " frame length"}, n, exp_len);
        chk(bad == 0, {req, " frame bytes"}, bad_act, bad_exp);
        chk(!busy && fill_count == 0 && st_txempty, "R10 end of send", int'(fill_count), 0);
        @(negedge clk);
        chk(!tx_valid && fill_count == 0, "R12 no write or request taken while busy",
            int'(fill_count), 0);
        mcount = 0;
        mlen = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fill_count == 0 && !busy && !tx_valid && !st_txerr && !st_txempty,
            "R1 reset state", int'(fill_count), 0);
    endtask

    // R2 storage and drop at full, then a manual send of the largest frame.
    task automatic t_fill_and_drop();
        thresh = 6'h3F; crc_en = 1'b1; pad_en = 1'b0;
        wr_word({16'hC0DE, 16'd2032});
        chk(fill_count == 4, "R2 header stored", int'(fill_count), 4);
        for (int k = 1; k < 512; k++) wr_word(pat(k));
        chk(fill_count == 2048 && !busy, "R2 full store, R5 threshold off", int'(fill_count), 2048);
        @(negedge clk);
        data_wr = 1'b1; data_word = 32'hFFFF_FFFF;
        @(negedge clk);
        data_wr = 1'b0;
        chk(fill_count == 2048, "R2 write dropped when full", int'(fill_count), 2048);
        pulse_req();
        chk(busy && tx_valid, "R7 manual send starts", int'(busy), 1);
        recv_frame(2046, "R2 R8 R9 byte order and cap", 1'b0);
    endtask

    // R3 and R11: rejected header, error ack, flush, done ack.
    task automatic t_errors();
        wr_word({16'h0000, 16'd2033});
        chk(st_txerr && fill_count == 0, "R3 too-long header", int'(fill_count), 0);
        wr_word({16'h0000, 16'd40});
        wr_word(pat(1));
        chk(fill_count == 8, "R3 store resumes after rejection", int'(fill_count), 8);
        ack_err();
        chk(!st_txerr && fill_count == 0, "R11 error ack flushes", int'(fill_count), 0);
        @(negedge clk);
        ack_txempty = 1'b1;
        @(negedge clk);
        ack_txempty = 1'b0;
        chk(!st_txempty, "R11 done ack clears", int'(st_txempty), 0);
    endtask

    // R4 R6: threshold 0, completeness with and without the check field.
    task automatic t_unpadded();
        thresh = 6'h00; crc_en = 1'b1; pad_en = 1'b0;
        fill_frame(20, 8);
        chk(!busy && fill_count == 32, "R4 one word short", int'(busy), 0);
        wr_word(pat(8));
        chk(busy && tx_valid, "R6 auto send at completion", int'(busy), 1);
        recv_frame(34, "R8 unpadded", 1'b0);
        crc_en = 1'b0;
        fill_frame(20, 9);
        chk(!busy && fill_count == 36, "R4 check field still expected", int'(busy), 0);
        wr_word(pat(9));
        chk(busy, "R4 R6 auto send with check field", int'(busy), 1);
        recv_frame(34, "R8 check field not sent", 1'b0);
        crc_en = 1'b1;
    endtask

    // R9 padding, with a write and request attempted mid-stream (R12).
    task automatic t_padded();
        thresh = 6'h00; crc_en = 1'b1; pad_en = 1'b1;
        fill_frame(10, 6);
        chk(!busy, "R4 short frame incomplete", int'(busy), 0);
        wr_word(pat(6));
        chk(busy, "R6 padded frame starts", int'(busy), 1);
        recv_frame(60, "R9 padded to minimum", 1'b1);
        pad_en = 1'b0;
    endtask

    // R5 highest active code, threshold gating, then a partial manual send.
    task automatic t_threshold();
        thresh = 6'h3E; crc_en = 1'b1; pad_en = 1'b0;
        fill_frame(1972, 496);
        chk(!busy && fill_count == 1984, "R5 below threshold 0x3E", int'(fill_count), 1984);
        wr_word(pat(496));
        chk(busy, "R5 threshold 0x3E reached", int'(busy), 1);
        recv_frame(1986, "R8 long frame", 1'b0);
        fill_frame(20, 10);
        chk(!busy && fill_count == 40, "R5 complete but under threshold", int'(busy), 0);
        ack_err();
        thresh = 6'h3F;
        fill_frame(100, 4);
        chk(!busy && fill_count == 16, "R5 disabled code holds frame", int'(busy), 0);
        pulse_req();
        chk(busy, "R7 partial frame send", int'(busy), 1);
        recv_frame(114, "R7 R8 partial frame zero fill", 1'b0);
    endtask

    initial begin
        t_reset();
        t_fill_and_drop();
        t_errors();
        t_unpadded();
        t_padded();
        t_threshold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule